// File: doc/BRIEF.md
# Up-Mode Period Timer

This block is a 16-bit counter that runs from zero up to a programmable period and then goes back to zero. It produces one cycle every period+1 timer ticks. A clock-enable input supplies the timer ticks. A one-bit mode input selects between stopped and counting. The period is written through a single-cycle register write port, and the new value takes effect on the next cycle. No deferred load is offered.

Two sticky interrupt flags report progress through each cycle. The match flag is set when the counter arrives at the period value. The wrap flag is set one tick later, when the counter returns from the period value to zero. Each flag has its own clear strobe.

The counter never runs past the period. If the counter already sits above the period, because up mode was entered late or because a shorter period was written while counting, the next tick returns it to zero. A synchronous counter clear input zeroes the count and leaves the period untouched.

Top module: `period_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes 0, `period` becomes the parameter `RST_PERIOD` (default 16'hFFFF), and both flags become 0.
- R2: In up mode (`mode` = 1), the counter increases by one on each edge where `tick` is 1. When `tick` is 0, the counter holds its value.
- R3: On a tick in up mode where `count` equals `period`, `count` becomes 0. A full cycle therefore lasts period+1 ticks.
- R4: `match_flag` is set on the tick that makes `count` equal to `period`.
- R5: `wrap_flag` is set on the tick where `count` goes from `period` to 0. This is one tick after `match_flag` is set. A forced restart from above the period does not set `wrap_flag`.
- R6: If up mode is selected while `count` is greater than `period`, the next tick sets `count` to 0.
- R7: A write (`prd_we` = 1) loads `prd_wdata` into `period` at that edge. If the new period is not below the current count, counting continues up to the new period before wrapping.
- R8: If the new period is below the current count, the counter returns to 0. This happens within two ticks: at most one extra count is allowed before the return.
- R9: In stop mode (`mode` = 0), `count` holds its value and no flag is set, whatever `tick` does.
- R10: `cnt_clr` zeroes `count` at the next edge. It has priority over a tick, leaves `period` unchanged and sets no flag.
- R11: Each flag stays set until its own clear strobe (`match_clr`, `wrap_clr`) is high at an edge. If a set and a clear fall on the same edge, the set wins.
- R12: With `period` = 0 in up mode, `count` stays 0 and both flags are set on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer clock enable, one count per high cycle |
| mode | input | 1 | 0 = stop, 1 = up |
| cnt_clr | input | 1 | Synchronous counter clear |
| prd_we | input | 1 | Period write strobe |
| prd_wdata | input | W | Period write data |
| match_clr | input | 1 | Clear strobe for the match flag |
| wrap_clr | input | 1 | Clear strobe for the wrap flag |
| count | output | W | Current counter value (registered) |
| period | output | W | Current period latch (registered) |
| match_flag | output | 1 | Sticky flag: counter reached the period |
| wrap_flag | output | 1 | Sticky flag: counter wrapped from the period to zero |

## Verification
Every result is registered once, so a tick, clear, period write or flag clear sampled at edge N shows up on the outputs just after edge N. The one exception is the shorter-period rollover, which may take one extra edge. The bench drives inputs 1 ns after a rising edge and reads the outputs at that same point after the following edge, so each check sees exactly one edge of effect. For the shorter-period case, the bench reads the count after the first tick and accepts either 0 or the count plus one. In the second case it ticks once more and then requires 0.

// File: rtl/period_timer_pkg.sv
package period_timer_pkg;

  typedef enum logic {
    MODE_STOP = 1'b0,
    MODE_UP   = 1'b1
  } pt_mode_e;

  localparam int unsigned N_FLAGS  = 2;
  localparam int unsigned FLG_MTCH = 0;
  localparam int unsigned FLG_WRAP = 1;

endpackage

// File: rtl/pt_period_reg.sv
module pt_period_reg #(
  parameter int unsigned W          = 16,
  parameter logic [W-1:0] RST_PERIOD = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] period_q
);

  // Immediate load: the new value is active from the cycle after the write.
  always_ff @(posedge clk) begin
    if (rst)     period_q <= RST_PERIOD;
    else if (we) period_q <= wdata;
  end

endmodule

// File: rtl/pt_counter.sv
module pt_counter
  import period_timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  pt_mode_e     mode,
  input  logic         clr,
  input  logic [W-1:0] period,
  output logic [W-1:0] count_q,
  output logic         match_ev,
  output logic         wrap_ev
);

  logic [W-1:0] count_d;
  logic         step;

  assign step = tick && (mode == MODE_UP) && !clr;

  always_comb begin
    count_d  = count_q;
    wrap_ev  = 1'b0;
    match_ev = 1'b0;
    if (clr) begin
      count_d = '0;
    end else if (step) begin
      if (count_q == period) begin
        count_d = '0;
        wrap_ev = 1'b1;
      end else if (count_q > period) begin
        // late entry or shortened period: restart without a wrap event
        count_d = '0;
      end else begin
        count_d = count_q + 1'b1;
      end
      match_ev = (count_d == period);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end

endmodule

// File: rtl/pt_flags.sv
module pt_flags #(
  parameter int unsigned NF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flag_q
);

  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flag_q[g] <= 1'b0;
      else if (set_i[g]) flag_q[g] <= 1'b1;
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/period_timer.sv
module period_timer
  import period_timer_pkg::*;
#(
  parameter int unsigned W          = 16,
  parameter logic [W-1:0] RST_PERIOD = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         mode,
  input  logic         cnt_clr,
  input  logic         prd_we,
  input  logic [W-1:0] prd_wdata,
  input  logic         match_clr,
  input  logic         wrap_clr,
  output logic [W-1:0] count,
  output logic [W-1:0] period,
  output logic         match_flag,
  output logic         wrap_flag
);

  logic                 match_ev;
  logic                 wrap_ev;
  logic [N_FLAGS-1:0]   fset;
  logic [N_FLAGS-1:0]   fclr;
  logic [N_FLAGS-1:0]   fq;

  pt_period_reg #(.W(W), .RST_PERIOD(RST_PERIOD)) prd_i (
    .clk      (clk),
    .rst      (rst),
    .we       (prd_we),
    .wdata    (prd_wdata),
    .period_q (period)
  );

  pt_counter #(.W(W)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .mode     (pt_mode_e'(mode)),
    .clr      (cnt_clr),
    .period   (period),
    .count_q  (count),
    .match_ev (match_ev),
    .wrap_ev  (wrap_ev)
  );

  always_comb begin
    fset           = '0;
    fclr           = '0;
    fset[FLG_MTCH] = match_ev;
    fset[FLG_WRAP] = wrap_ev;
    fclr[FLG_MTCH] = match_clr;
    fclr[FLG_WRAP] = wrap_clr;
  end

  pt_flags #(.NF(N_FLAGS)) flg_i (
    .clk    (clk),
    .rst    (rst),
    .set_i  (fset),
    .clr_i  (fclr),
    .flag_q (fq)
  );

  assign match_flag = fq[FLG_MTCH];
  assign wrap_flag  = fq[FLG_WRAP];

endmodule

// File: rtl/period_timer_chk.sv
module period_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         mode,
  input logic         cnt_clr,
  input logic         match_clr,
  input logic         wrap_clr,
  input logic [W-1:0] count,
  input logic [W-1:0] period,
  input logic         match_flag,
  input logic         wrap_flag
);

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && mode && !cnt_clr && count == period) |=> (count == '0 && wrap_flag));

  // R6
  above_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && mode && !cnt_clr && count > period) |=> (count == '0));

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && !cnt_clr) |=> $stable(count));

  // R9
  stop_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && !match_flag && !wrap_flag) |=> (!match_flag && !wrap_flag));

  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (count == '0 && $stable(period)));

  // R11
  match_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (match_flag && !match_clr) |=> match_flag);

  // R11
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap_flag && !wrap_clr) |=> wrap_flag);

  // R4
  match_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(match_flag) |-> (count == $past(period)));

  // R12
  zero_period_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && mode && !cnt_clr && period == '0) |=> (count == '0 && match_flag && wrap_flag));

endmodule

bind period_timer period_timer_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .mode       (mode),
  .cnt_clr    (cnt_clr),
  .match_clr  (match_clr),
  .wrap_clr   (wrap_clr),
  .count      (count),
  .period     (period),
  .match_flag (match_flag),
  .wrap_flag  (wrap_flag)
);

// File: tb/period_timer_tb_top.sv
`timescale 1ns/1ps
module period_timer_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         mode = 1'b0;
  logic         cnt_clr = 1'b0;
  logic         prd_we = 1'b0;
  logic [W-1:0] prd_wdata = '0;
  logic         match_clr = 1'b0;
  logic         wrap_clr = 1'b0;
  logic [W-1:0] count;
  logic [W-1:0] period;
  logic         match_flag;
  logic         wrap_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  period_timer #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .cnt_clr(cnt_clr),
    .prd_we(prd_we), .prd_wdata(prd_wdata), .match_clr(match_clr),
    .wrap_clr(wrap_clr), .count(count), .period(period),
    .match_flag(match_flag), .wrap_flag(wrap_flag)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_period(input logic [W-1:0] v);
    tick = 1'b0; prd_we = 1'b1; prd_wdata = v;
    step();
    prd_we = 1'b0;
  endtask

  task automatic clr_flags();
    tick = 1'b0; match_clr = 1'b1; wrap_clr = 1'b1;
    step();
    match_clr = 1'b0; wrap_clr = 1'b0;
  endtask

  task automatic clr_count();
    tick = 1'b0; cnt_clr = 1'b1;
    step();
    cnt_clr = 1'b0;
  endtask

  task automatic run(input int n);
    mode = 1'b1; tick = 1'b1;
    for (int i = 0; i < n; i++) step();
    tick = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) step();
    rst = 1'b0;
    chk("R1", "count", count, 0);
    chk("R1", "period", period, 16'hFFFF);
    chk("R1", "flags", {match_flag, wrap_flag}, 0);
  endtask

  task automatic t_basic();
    wr_period(3);
    chk("R7", "period load", period, 3);
    run(2);
    chk("R2", "count after 2 ticks", count, 2);
    mode = 1'b1; tick = 1'b0;
    step(); step();
    chk("R2", "hold without tick", count, 2);
    chk("R4", "match early", match_flag, 0);
    run(1);
    chk("R2", "count at period", count, 3);
    chk("R4", "match set", match_flag, 1);
    chk("R5", "wrap not yet", wrap_flag, 0);
    run(1);
    chk("R3", "wrap to zero", count, 0);
    chk("R5", "wrap set", wrap_flag, 1);
    clr_flags();
    run(4);
    chk("R3", "period+1 ticks per cycle", count, 0);
    chk("R5", "wrap again", wrap_flag, 1);
  endtask

  task automatic t_stop();
    clr_flags();
    run(3);
    chk("R9", "pre-stop count", count, 3);
    clr_flags();
    mode = 1'b0; tick = 1'b1;
    for (int i = 0; i < 5; i++) step();
    tick = 1'b0;
    chk("R9", "stop holds count", count, 3);
    chk("R9", "stop sets no flag", {match_flag, wrap_flag}, 0);
  endtask

  task automatic t_clear();
    wr_period(8);
    clr_count();
    run(6);
    clr_flags();
    mode = 1'b1; tick = 1'b1; cnt_clr = 1'b1;
    step();
    cnt_clr = 1'b0; tick = 1'b0;
    chk("R10", "count zeroed", count, 0);
    chk("R10", "period kept", period, 8);
    chk("R10", "no flag", {match_flag, wrap_flag}, 0);
  endtask

  task automatic t_sticky();
    wr_period(3);
    clr_count();
    clr_flags();
    run(3);
    chk("R11", "match set", match_flag, 1);
    mode = 1'b1; tick = 1'b0;
    repeat (4) step();
    chk("R11", "match stays", match_flag, 1);
    match_clr = 1'b1; step(); match_clr = 1'b0;
    chk("R11", "match cleared", match_flag, 0);
    chk("R11", "wrap untouched by match clear", wrap_flag, 0);
    clr_count();
    run(2);
    mode = 1'b1; tick = 1'b1; match_clr = 1'b1;
    step();
    tick = 1'b0; match_clr = 1'b0;
    chk("R11", "set beats clear", match_flag, 1);
  endtask

  task automatic t_enter_above();
    clr_count();
    wr_period(10);
    run(8);
    mode = 1'b0;
    wr_period(5);
    clr_flags();
    chk("R6", "count above period", count, 8);
    run(1);
    chk("R6", "restart to zero", count, 0);
    chk("R5", "no wrap on forced restart", wrap_flag, 0);
  endtask

  task automatic t_longer();
    clr_count();
    wr_period(5);
    run(4);
    clr_flags();
    mode = 1'b1;
    wr_period(9);
    run(1);
    chk("R7", "passes old period", count, 5);
    chk("R7", "no match at old period", match_flag, 0);
    run(4);
    chk("R7", "reaches new period", count, 9);
    chk("R7", "match at new period", match_flag, 1);
    run(1);
    chk("R7", "wraps after new period", count, 0);
  endtask

  task automatic t_shorter();
    clr_count();
    wr_period(9);
    run(7);
    mode = 1'b1;
    wr_period(4);
    run(1);
    if (count == 8) run(1);
    chk("R8", "rollover after shorter period", count, 0);
    run(4);
    chk("R8", "new period used", count, 4);
  endtask

  task automatic t_zero();
    wr_period(0);
    clr_count();
    clr_flags();
    run(1);
    chk("R12", "count stays zero", count, 0);
    chk("R12", "both flags", {match_flag, wrap_flag}, 3);
    mode = 1'b1; tick = 1'b1; match_clr = 1'b1; wrap_clr = 1'b1;
    step();
    chk("R12", "set again each tick", {match_flag, wrap_flag}, 3);
    tick = 1'b0;
    step();
    match_clr = 1'b0; wrap_clr = 1'b0;
    chk("R11", "cleared without tick", {match_flag, wrap_flag}, 0);
    run(3);
    chk("R12", "count after ticks", count, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_stop();
    t_clear();
    t_sticky();
    t_enter_above();
    t_longer();
    t_shorter();
    t_zero();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule